// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Conditioner

This block runs from one fast reference clock and produces the timing signals a small processor system needs. It passes the reference through unchanged. It divides the reference by three into a processor clock that is high for one third of each period. It divides that clock by two again into a peripheral clock. All derived clocks are registered outputs of the reference domain.

An asynchronous active-low reset request becomes an active-high reset output. The output asserts as soon as the request arrives and releases in step with the processor clock. Two bus-ready requests are each qualified by an active-low address enable, one per bus master, and the result is synchronized to the processor clock. A mode input selects whether ready is sampled through one stage or two.

Top module: `cpu_clock_conditioner`

## Requirements
- R1: `osc_out` equals `ref_clk` at all times.
- R2: `pclk` has a period of 3 reference cycles and is high for exactly 1 of them.
- R3: `perclk` toggles at every rising edge of `pclk`, so it is high for 3 reference cycles and low for 3.
- R4: While `rst_req_n` is low, `pclk`, `perclk` and `rdy_out` are 0 and `rst_out` is 1. The first reference rising edge after release drives `pclk` to 1 and `perclk` to 1.
- R5: After release, `rst_out` stays 1 through four reference rising edges and drops to 0 at the fifth, which is the second falling edge of `pclk`. It never falls at any other kind of edge.
- R6: The qualified ready is `(rdy_a & ~bus_en_a_n) | (rdy_b & ~bus_en_b_n)`. Each enable is active low, and either bus alone can grant ready.
- R7: With `sync_single` = 1, `rdy_out` takes the qualified ready at the next falling edge of `pclk`.
- R8: With `sync_single` = 0, the qualified ready is captured at a rising edge of `pclk` and passed to `rdy_out` at the following falling edge.
- R9: `rdy_out` changes only at reference edges where `pclk` falls, so it is held for a full `pclk` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| rdy_a | input | 1 | Ready request from bus A |
| rdy_b | input | 1 | Ready request from bus B |
| bus_en_a_n | input | 1 | Address enable for bus A, active low |
| bus_en_b_n | input | 1 | Address enable for bus B, active low |
| sync_single | input | 1 | 1: one-stage ready sampling; 0: two-stage |
| osc_out | output | 1 | Reference pass-through |
| pclk | output | 1 | Processor clock, reference/3, 1/3 duty |
| perclk | output | 1 | Peripheral clock, reference/6 |
| rst_out | output | 1 | Reset to processor, active high |
| rdy_out | output | 1 | Synchronized ready |

## Verification
A phase counter that skips or repeats a state shows up within three reference cycles as a `pclk` high pulse of the wrong length or spacing, and within six cycles as a `perclk` level that does not match. A reset synchronizer with the wrong depth or the wrong sampling edge moves the fall of `rst_out` off the fifth edge after release. A ready path sampled on the wrong edge, or through the wrong number of stages, shifts `rdy_out` by whole reference cycles. The bench catches this by counting edges from a known `pclk` phase.

// File: rtl/cpu_clock_conditioner.sv
module cpu_clock_conditioner (
  input  logic ref_clk,
  input  logic rst_req_n,
  input  logic rdy_a,
  input  logic rdy_b,
  input  logic bus_en_a_n,
  input  logic bus_en_b_n,
  input  logic sync_single,
  output logic osc_out,
  output logic pclk,
  output logic perclk,
  output logic rst_out,
  output logic rdy_out
);

  logic [1:0] phase;
  logic       rst_s1;
  logic       rdy_rise;
  logic       rdy_raw;
  logic       rise_next;

  assign osc_out   = ref_clk;
  assign rise_next = (phase == 2'd2);
  assign rdy_raw   = (rdy_a & ~bus_en_a_n) | (rdy_b & ~bus_en_b_n);

  always_ff @(posedge ref_clk or negedge rst_req_n) begin
    if (!rst_req_n) begin
      phase    <= 2'd2;
      pclk     <= 1'b0;
      perclk   <= 1'b0;
      rst_s1   <= 1'b1;
      rst_out  <= 1'b1;
      rdy_rise <= 1'b0;
      rdy_out  <= 1'b0;
    end else begin
      phase <= rise_next ? 2'd0 : phase + 2'd1;
      pclk  <= rise_next;
      if (rise_next) begin
        perclk   <= ~perclk;
        rdy_rise <= rdy_raw;
      end
      if (pclk) begin
        rst_s1  <= 1'b0;
        rst_out <= rst_s1;
        rdy_out <= sync_single ? rdy_raw : rdy_rise;
      end
    end
  end

  assert_pclk_shape_R2: assert property (@(posedge ref_clk) disable iff (!rst_req_n)
    pclk |=> !pclk ##1 !pclk ##1 pclk);

  assert_perclk_toggle_R3: assert property (@(posedge ref_clk) disable iff (!rst_req_n)
    $rose(pclk) |-> (perclk != $past(perclk)));

  assert_rst_release_edge_R5: assert property (@(posedge ref_clk) disable iff (!rst_req_n)
    $fell(rst_out) |-> $past(pclk));

  assert_rdy_hold_R9: assert property (@(posedge ref_clk) disable iff (!rst_req_n)
    (rdy_out != $past(rdy_out)) |-> $past(pclk));

endmodule

// File: tb/sim_cpu_clock_conditioner.sv
module sim_cpu_clock_conditioner;
  logic ref_clk = 1'b0;
  logic rst_req_n = 1'b0;
  logic rdy_a = 1'b0, rdy_b = 1'b0;
  logic bus_en_a_n = 1'b1, bus_en_b_n = 1'b1;
  logic sync_single = 1'b0;
  logic osc_out, pclk, perclk, rst_out, rdy_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 ref_clk = ~ref_clk;

  cpu_clock_conditioner u0 (
    .ref_clk(ref_clk), .rst_req_n(rst_req_n), .rdy_a(rdy_a), .rdy_b(rdy_b),
    .bus_en_a_n(bus_en_a_n), .bus_en_b_n(bus_en_b_n), .sync_single(sync_single),
    .osc_out(osc_out), .pclk(pclk), .perclk(perclk), .rst_out(rst_out), .rdy_out(rdy_out));

  // {sync_single, rdy_a, bus_en_a_n, rdy_b, bus_en_b_n, expected rdy_out}
  localparam logic [5:0] VEC [16] = '{
    6'b0_0_0_0_0_0, 6'b0_1_0_0_0_1, 6'b0_1_1_0_0_0, 6'b0_0_0_1_0_1,
    6'b0_0_0_1_1_0, 6'b0_1_1_1_1_0, 6'b0_1_0_1_1_1, 6'b0_1_1_1_0_1,
    6'b1_1_0_1_0_1, 6'b1_0_1_0_1_0, 6'b1_1_0_0_1_1, 6'b1_0_0_1_0_1,
    6'b1_1_1_0_0_0, 6'b1_0_1_1_0_1, 6'b1_1_1_1_1_0, 6'b1_1_0_1_1_1};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic sync_to_rise;
    @(negedge ref_clk);
    while (pclk !== 1'b1) @(negedge ref_clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rdy_a = 1'b1; bus_en_a_n = 1'b0;
    step(2);
    // R4: state held in reset, even with ready requested
    check("R4 pclk", pclk, 1'b0);
    check("R4 perclk", perclk, 1'b0);
    check("R4 rst_out", rst_out, 1'b1);
    check("R4 rdy_out", rdy_out, 1'b0);
    // R1: pass-through on both levels
    check("R1 low", osc_out, 1'b0);
    @(posedge ref_clk); #1 check("R1 high", osc_out, 1'b1);
    rdy_a = 1'b0; bus_en_a_n = 1'b1;
    @(negedge ref_clk);
    rst_req_n = 1'b1;
    // R2 R3 R4 R5: edge-by-edge pattern after release
    for (int e = 1; e <= 12; e++) begin
      @(negedge ref_clk);
      check("R2 pclk pattern", pclk, ((e - 1) % 3) == 0);
      check("R3 perclk pattern", perclk, ((e - 1) % 6) < 3);
      check("R5 rst_out release", rst_out, e < 5);
    end

    // R6 R7 R8: qualified ready table
    foreach (VEC[k]) begin
      {sync_single, rdy_a, bus_en_a_n, rdy_b, bus_en_b_n} = VEC[k][5:1];
      step(6);
      check(VEC[k][5] ? "R6 R7 table" : "R6 R8 table", rdy_out, VEC[k][0]);
    end

    // R8: two-stage latency measured from a pclk rising edge
    sync_single = 1'b0; rdy_a = 1'b0; rdy_b = 1'b0;
    step(6);
    sync_to_rise;
    rdy_a = 1'b1; bus_en_a_n = 1'b0;
    step(1); check("R8 not yet at first fall", rdy_out, 1'b0);
    step(2); check("R8 not yet before rise", rdy_out, 1'b0);
    step(1); check("R8 set at second fall", rdy_out, 1'b1);

    // R7: single-stage takes the next fall
    sync_single = 1'b1;
    sync_to_rise;
    rdy_a = 1'b0;
    step(1); check("R7 cleared at next fall", rdy_out, 1'b0);

    // R9: a change just after a fall waits a full pclk period
    rdy_b = 1'b1; bus_en_b_n = 1'b0;
    step(1); check("R9 held edge 1", rdy_out, 1'b0);
    step(1); check("R9 held edge 2", rdy_out, 1'b0);
    step(1); check("R9 update at fall", rdy_out, 1'b1);

    // R4: reset mid-run takes effect at once
    rst_req_n = 1'b0;
    #1;
    check("R4 async rst_out", rst_out, 1'b1);
    check("R4 async pclk", pclk, 1'b0);
    check("R4 async rdy_out", rdy_out, 1'b0);
    step(1);
    rst_req_n = 1'b1;
    step(1); check("R4 first rise", pclk, 1'b1);
    check("R4 first perclk", perclk, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule